// File: doc/BRIEF.md
# Linked-List Summing Engine

This block walks a singly linked list stored in a single-ported, asynchronously read memory and adds up the signed values held in its nodes. Every node occupies two consecutive words. The word at the node address holds the pointer to the next node, and the word after it holds the node's two's-complement value. The list always starts at address 0 and ends at the node whose pointer is 0. A list always has at least one node.

A one-cycle `start` pulse begins a walk from the head. The engine then repeats a two-cycle loop. In the first cycle it reads the current node's value word and adds it to the running total. In the second cycle it reads the pointer word, which gives the next node address and that node's value address (pointer plus one). When it reads a null pointer, it places the total on `result`, raises `done` and goes idle. While idle it does not use the memory. It holds `done` and `result` until the next `start`.

A parameter selects whether one adder is shared between accumulation and the address increment, or whether each has its own adder. A second parameter widens the total beyond the data width. In that case node values are sign-extended before they are added.

Top module: `list_sum_engine`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: A `start` sampled high clears the running total and restarts the walk at address 0. `done` is 0 in the cycle after that edge.
- R3: While busy the engine drives one address per cycle. For the k-th node at address A (the head is A=0), it drives A+1 (value word) and then, in the next cycle, A (pointer word).
- R4: For a list of N nodes, `done` rises exactly 2N clock edges after the edge that sampled `start`, and stays 0 until then.
- R5: `result` equals the sum of all node values, read as 8-bit two's complement, taken modulo 2^SUM_W.
- R6: A list whose head pointer (address 0) is 0 is a single node. Its result is the value at address 1, with `done` after 2 cycles.
- R7: Once `done` is high, `done` and `result` hold unchanged on every idle cycle until the next `start`, whatever the memory returns.
- R8: A `start` arriving while a walk is in progress abandons that walk and begins a fresh one from address 0.
- R9: With SHARE_ADDER=1 the engine produces the same address sequence, timing and result as with separate adders.
- R10: With SUM_W greater than 8, each node value is sign-extended before it is added. For example, three values of 100 give 300, and a value of 0x80 counts as -128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a walk from address 0 |
| mem_addr | output | W | Memory read address |
| mem_rdata | input | W | Asynchronous read data for `mem_addr` |
| result | output | SUM_W | Final sum, valid while `done` is high |
| done | output | 1 | Walk finished; held until next `start` |

## Verification
The hardest case to reach from the ports is a restart in the middle of a walk. Here `start` arrives when the running total and the pointer registers hold partial values from a half-walked list. The stimulus pulses `start` a few cycles into a long walk. It does this both on a value cycle and on a pointer cycle, so stale state would show up in the address sequence or the total. Wrap-around and sign extension are reached with lists whose values overflow 8 bits. Two engines, one shared-adder and narrow and one with separate adders and a wide total, run side by side on the same memory image.

// File: rtl/list_sum_engine.sv
module list_sum_engine #(
  parameter int W           = 8,
  parameter int SUM_W       = 8,
  parameter bit SHARE_ADDER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [W-1:0]     mem_addr,
  input  logic [W-1:0]     mem_rdata,
  output logic [SUM_W-1:0] result,
  output logic             done
);

  typedef enum logic [1:0] {ST_IDLE, ST_VAL, ST_PTR} state_t;

  state_t           state_q;
  logic [W-1:0]     next_q;
  logic [W-1:0]     numa_q;
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] sum_nx;
  logic [W-1:0]     numa_nx;
  logic [SUM_W-1:0] val_ext;
  logic             busy;

  assign busy     = (state_q != ST_IDLE);
  assign mem_addr = (state_q == ST_VAL) ? numa_q : next_q;
  assign val_ext  = SUM_W'($signed(mem_rdata));

  generate
    if (SHARE_ADDER) begin : g_shared
      logic [SUM_W-1:0] add_a, add_b, add_y;
      assign add_a   = (state_q == ST_VAL) ? sum_q   : SUM_W'(mem_rdata);
      assign add_b   = (state_q == ST_VAL) ? val_ext : SUM_W'(1);
      assign add_y   = add_a + add_b;
      assign sum_nx  = add_y;
      assign numa_nx = add_y[W-1:0];
    end else begin : g_split
      assign sum_nx  = sum_q + val_ext;
      assign numa_nx = mem_rdata + W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      next_q  <= '0;
      numa_q  <= W'(1);
      sum_q   <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else if (start) begin
      state_q <= ST_VAL;
      next_q  <= '0;
      numa_q  <= W'(1);
      sum_q   <= '0;
      done    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_VAL: begin
          sum_q   <= sum_nx;
          state_q <= ST_PTR;
        end
        ST_PTR: begin
          next_q <= mem_rdata;
          numa_q <= numa_nx;
          if (mem_rdata == '0) begin
            result  <= sum_q;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_VAL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

module list_sum_engine_chk #(
  parameter int SUM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [SUM_W-1:0] result
);

  p_start_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && busy));

  p_no_done_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_done_on_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));

  p_idle_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

endmodule

bind list_sum_engine list_sum_engine_chk #(.SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .result(result)
);

// File: tb/list_sum_engine_tb.sv
`timescale 1ns/100ps
module list_sum_engine_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  mem [256];
  logic [7:0]  addr_a, addr_b;
  logic [7:0]  res_a;
  logic [11:0] res_b;
  logic        done_a, done_b;

  list_sum_engine #(.W(8), .SUM_W(8), .SHARE_ADDER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(addr_a),
    .mem_rdata(mem[addr_a]), .result(res_a), .done(done_a));

  list_sum_engine #(.W(8), .SUM_W(12), .SHARE_ADDER(1'b0)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(addr_b),
    .mem_rdata(mem[addr_b]), .result(res_b), .done(done_b));

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int  nodes[$];
  int  m_pos = 0, m_steps = 0;
  bit  m_busy = 0, m_done = 0;
  int  m_sum = 0, m_res = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_res = 0;
    end else if (start) begin
      int a;
      nodes.delete();
      a = 0; m_sum = 0;
      do begin
        nodes.push_back(a);
        m_sum += int'($signed(mem[(a + 1) % 256]));
        a = mem[a];
      end while (a != 0 && nodes.size() < 128);
      m_steps = 2 * nodes.size();
      m_pos = 0; m_busy = 1; m_done = 0;
    end else if (m_busy) begin
      m_pos++;
      if (m_pos == m_steps) begin
        m_busy = 0; m_done = 1; m_res = m_sum;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done_a == m_done, {tag, " R4 done (R9 shared)"}, done_a, m_done);
      chk(done_b == m_done, {tag, " R4 done (wide)"}, done_b, m_done);
      if (m_busy) begin
        int exp_addr;
        exp_addr = (m_pos % 2 == 0) ? (nodes[m_pos/2] + 1) % 256 : nodes[m_pos/2];
        chk(addr_a == exp_addr, {tag, " R3 addr (R9 shared)"}, addr_a, exp_addr);
        chk(addr_b == exp_addr, {tag, " R3 addr (wide)"}, addr_b, exp_addr);
      end
      if (m_done) begin
        chk(res_a == (m_res & 32'hFF), {tag, " R5 result 8-bit (R9)"}, res_a, m_res & 32'hFF);
        chk(res_b == (m_res & 32'hFFF), {tag, " R10 result 12-bit"}, res_b, m_res & 32'hFFF);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic run_to_done(input int extra);
    pulse_start();
    for (int i = 0; i < 600 && !done_a; i++) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(done_a == 0 && res_a == 0, "R1 reset (shared)", {done_a, res_a}, 0);
    chk(done_b == 0 && res_b == 0, "R1 reset (wide)", {done_b, res_b}, 0);

    tag = "R6";
    mem[0] = 8'd0; mem[1] = 8'd5;
    run_to_done(3);
    chk(res_a == 8'd5, "R6 single node", res_a, 5);

    tag = "R5";
    mem[0] = 8'd10; mem[1] = 8'd100;
    mem[10] = 8'd20; mem[11] = 8'd100;
    mem[20] = 8'd0;  mem[21] = 8'd100;
    run_to_done(2);
    chk(res_a == 8'd44, "R5 wrap 300 mod 256", res_a, 44);
    chk(res_b == 12'd300, "R10 wide 300", res_b, 300);

    tag = "R7";
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
    repeat (8) @(negedge clk);
    chk(done_a == 1'b1, "R7 hold done", done_a, 1);

    tag = "R10";
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    mem[0] = 8'd40; mem[1] = 8'hFD;
    mem[40] = 8'd90; mem[41] = 8'h80;
    mem[90] = 8'd0;  mem[91] = 8'd7;
    run_to_done(2);
    chk(res_b == 12'hF84, "R10 sign extension -124", res_b, 12'hF84);

    tag = "R2";
    pulse_start();
    chk(done_a == 1'b0, "R2 done cleared by start", done_a, 0);
    for (int i = 0; i < 50 && !done_a; i++) @(negedge clk);

    tag = "R8";
    for (int i = 0; i < 60; i++) begin
      mem[4*i]     = (i == 59) ? 8'd0 : 8'(4*(i+1));
      mem[4*i + 1] = 8'(i * 13 - 50);
    end
    pulse_start();
    repeat (3) @(negedge clk);
    run_to_done(0);
    pulse_start();
    repeat (6) @(negedge clk);
    run_to_done(4);

    tag = "R4";
    run_to_done(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule